// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command bus of a four-bank double-data-rate SDRAM from the device side. On every rising clock edge it decodes chip select, the three command strobes and the clock enable into one command. It tracks, for each bank, whether a row is open and which row that is. It also reports which power state the device is in. It raises a one-cycle error flag when the command stream breaks a sequencing rule. Examples are an access to a bank with no open row, an activate on a bank that is already open, a refresh while rows are open, and clock enable dropping during a burst.

Address bit 10 and the bank inputs mean different things for different commands:
- On a precharge, bit 10 selects one bank or all banks.
- On a read or write, bit 10 requests auto precharge.
- On a mode-register write, the bank inputs pick the base or the extended register.

An auto-precharge access closes its bank on its own once the burst has run out. The burst length comes from a configuration input. When clock enable is held low, the power state splits three ways: active power-down, precharge power-down and self refresh. Which one applies depends on whether any row is open and on which command went with the falling clock enable.

All outputs are registered. The result for a command sampled at edge k is visible right after edge k.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: A command sampled with `cs_n` high is a deselect. `cmd_o` reads NOP (0) and no bank state changes.
- R2: An activate ({cs_n,ras_n,cas_n,we_n}=0011) on an idle bank marks bank `ba` open. It stores `addr` as that bank's row in `open_row_o[ba*12 +: 12]`.
- R3: A read (0101) or write (0100) to an idle bank sets `err_idle_o` and starts no burst. An activate on an open bank sets `err_act_o` and leaves the stored row unchanged.
- R4: A read or write loads `col_o` from `addr[9:0]`, with `addr[11]` added as the top bit when `COL_W` is 11. It loads `auto_pre_o` from `addr[10]`.
- R5: A precharge (0010) with `addr[10]`=0 closes bank `ba`. With `addr[10]`=1 it closes all banks.
- R6: An auto refresh (0001), or a self-refresh entry, while any bank is open sets `err_ref_o`.
- R7: A valid read or write with auto precharge closes its bank BL/2 cycles after the command's edge. Here `bl_sel` 0, 1, 2/3 selects BL 2, 4, 8.
- R8: Clock enable sampled low in the normal state enters active power-down (`pwr_o`=2) if any bank is open, or precharge power-down (`pwr_o`=1) if none is. Commands are ignored while in power-down.
- R9: An auto-refresh code with clock enable low enters self refresh (`pwr_o`=3, `cmd_o`=8). From any low-power state, the first edge that samples clock enable high returns to normal (`pwr_o`=0), and the command at that edge is ignored.
- R10: A mode-register write (0000) sets `mrs_ext_o` to `ba[0]`, where 1 means the extended register.
- R11: Clock enable sampled low while a read or write burst is still running sets `err_cke_o`.
- R12: `cmd_o` encodes NOP 0, activate 1, read 2, write 3, precharge 4, refresh 5, mode write 6, burst stop (0110) 7, self-refresh entry 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column, auto-precharge and mode bits |
| bl_sel | input | 2 | Burst length select |
| cmd_o | output | 4 | Decoded command |
| col_o | output | COL_W | Column of the last read or write |
| auto_pre_o | output | 1 | Auto precharge of the last read or write |
| mrs_ext_o | output | 1 | Last mode write targeted the extended register |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 48 | Per-bank open row, bank 0 in the low bits |
| pwr_o | output | 2 | Power state: 0 normal, 1 precharge PD, 2 active PD, 3 self refresh |
| err_idle_o | output | 1 | Access to an idle bank |
| err_act_o | output | 1 | Activate on an open bank |
| err_ref_o | output | 1 | Refresh with a bank open |
| err_cke_o | output | 1 | Clock enable low during a burst |

## Verification
The decoder is tried with every command code, including a deselect whose strobes alone would form a mode write. This separates chip-select masking from strobe decoding. Bank tracking is tried with interleaved activates on different banks, single-bank and all-bank precharge, and repeated activates. These separate the per-bank bookkeeping from the bit-10 interpretation. The power-state patterns drop clock enable once with a row open, once with all banks idle and once together with a refresh code. They then show that commands issued while clock enable is low or at the exit edge leave the banks untouched. Auto-precharge reads at burst lengths 4 and 8 pin down the exact closing cycle. A clock-enable drop right after a read separates the burst error from a plain power-down entry.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_REF  = 4'd5,
        CMD_MRS  = 4'd6,
        CMD_BST  = 4'd7,
        CMD_SREF = 4'd8
    } cmd_t;

    typedef enum logic [1:0] {
        PWR_ON     = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_ACT_PD = 2'd2,
        PWR_SREF   = 2'd3
    } pwr_t;

endpackage

// File: rtl/ddrmon_cmd_decode.sv
module ddrmon_cmd_decode
    import ddrmon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddrmon_col_pick.sv
module ddrmon_col_pick #(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col
);
    if (COL_W == 11) begin : g_x4
        // bit 10 carries auto precharge, so the column skips it
        assign col = {addr[11], addr[9:0]};
        logic unused_a10;
        assign unused_a10 = addr[10];
    end else begin : g_x8
        assign col = addr[COL_W-1:0];
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:COL_W];
    end
endmodule

// File: rtl/ddrmon_burst_timer.sv
module ddrmon_burst_timer #(
    parameter int MAX_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] bl_sel,
    output logic       active,
    output logic       expire
);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, len;

    always_comb begin
        unique case (bl_sel)
            2'd0:    len = CNT_W'(1);
            2'd1:    len = CNT_W'(2);
            default: len = CNT_W'(MAX_CYC);
        endcase
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
        active = (cnt_q != '0);
        expire = (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddrmon_pkg::*;
#(
    parameter int NB      = 4,
    parameter int ADDR_W  = 12,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 10,
    parameter int MAX_CYC = 4,
    localparam int BA_W   = $clog2(NB)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  cke,
    input  logic [BA_W-1:0]       ba,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            bl_sel,
    output logic [3:0]            cmd_o,
    output logic [COL_W-1:0]      col_o,
    output logic                  auto_pre_o,
    output logic                  mrs_ext_o,
    output logic [NB-1:0]         bank_open_o,
    output logic [NB*ROW_W-1:0]   open_row_o,
    output logic [1:0]            pwr_o,
    output logic                  err_idle_o,
    output logic                  err_act_o,
    output logic                  err_ref_o,
    output logic                  err_cke_o
);
    typedef struct packed {
        logic [NB-1:0]            open;
        logic [NB-1:0]            pend;
        logic [NB-1:0][ROW_W-1:0] row;
        cmd_t                     cmd;
        logic [COL_W-1:0]         col;
        logic                     ap;
        logic                     mrs_ext;
        pwr_t                     pwr;
        logic                     err_idle;
        logic                     err_act;
        logic                     err_ref;
        logic                     err_cke;
    } state_t;

    state_t           s_d, s_q;
    cmd_t             raw_cmd;
    logic [COL_W-1:0] col_w;
    logic             burst_start, burst_active, burst_expire;

    ddrmon_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(raw_cmd)
    );

    ddrmon_col_pick #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_col (
        .addr(addr), .col(col_w)
    );

    ddrmon_burst_timer #(.MAX_CYC(MAX_CYC)) u_tmr (
        .clk   (clk),          .rst_n (rst_n),
        .start (burst_start),  .bl_sel(bl_sel),
        .active(burst_active), .expire(burst_expire)
    );

    always_comb begin
        s_d          = s_q;
        s_d.cmd      = CMD_NOP;
        s_d.err_idle = 1'b0;
        s_d.err_act  = 1'b0;
        s_d.err_ref  = 1'b0;
        s_d.err_cke  = 1'b0;
        burst_start  = 1'b0;

        // auto-precharge closes take effect before this edge's command
        if (burst_expire) begin
            s_d.open = s_d.open & ~s_d.pend;
            s_d.pend = '0;
        end

        if (s_q.pwr == PWR_ON) begin
            if (!cke) begin
                if (burst_active) s_d.err_cke = 1'b1;
                if (raw_cmd == CMD_REF) begin
                    s_d.pwr     = PWR_SREF;
                    s_d.cmd     = CMD_SREF;
                    s_d.err_ref = |s_d.open;
                end else if (|s_d.open) begin
                    s_d.pwr = PWR_ACT_PD;
                end else begin
                    s_d.pwr = PWR_PRE_PD;
                end
            end else begin
                s_d.cmd = raw_cmd;
                unique case (raw_cmd)
                    CMD_ACT: begin
                        if (s_d.open[ba]) begin
                            s_d.err_act = 1'b1;
                        end else begin
                            s_d.open[ba] = 1'b1;
                            s_d.row[ba]  = addr[ROW_W-1:0];
                        end
                    end
                    CMD_RD, CMD_WR: begin
                        s_d.col = col_w;
                        s_d.ap  = addr[10];
                        if (!s_d.open[ba]) begin
                            s_d.err_idle = 1'b1;
                        end else begin
                            burst_start = 1'b1;
                            if (addr[10]) s_d.pend[ba] = 1'b1;
                        end
                    end
                    CMD_PRE: begin
                        if (addr[10]) begin
                            s_d.open = '0;
                            s_d.pend = '0;
                        end else begin
                            s_d.open[ba] = 1'b0;
                            s_d.pend[ba] = 1'b0;
                        end
                    end
                    CMD_REF: s_d.err_ref = |s_d.open;
                    CMD_MRS: s_d.mrs_ext = ba[0];
                    default: ;
                endcase
            end
        end else if (cke) begin
            s_d.pwr = PWR_ON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmd <= CMD_NOP;
            s_q.pwr <= PWR_ON;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o       = s_q.cmd;
    assign col_o       = s_q.col;
    assign auto_pre_o  = s_q.ap;
    assign mrs_ext_o   = s_q.mrs_ext;
    assign bank_open_o = s_q.open;
    assign open_row_o  = s_q.row;
    assign pwr_o       = s_q.pwr;
    assign err_idle_o  = s_q.err_idle;
    assign err_act_o   = s_q.err_act;
    assign err_ref_o   = s_q.err_ref;
    assign err_cke_o   = s_q.err_cke;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk
    import ddrmon_pkg::*;
#(
    parameter int NB     = 4,
    parameter int ADDR_W = 12,
    parameter int ROW_W  = 12,
    parameter int BA_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                cke,
    input logic [BA_W-1:0]     ba,
    input logic [ADDR_W-1:0]   addr,
    input logic [3:0]          cmd_o,
    input logic [NB-1:0]       bank_open_o,
    input logic [NB*ROW_W-1:0] open_row_o,
    input logic [1:0]          pwr_o,
    input logic                err_idle_o,
    input logic                err_act_o,
    input logic                err_cke_o
);
    AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> cmd_o == CMD_NOP); // R1
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !err_act_o) |->
        (bank_open_o[$past(ba)] &&
         open_row_o[$past(ba)*ROW_W +: ROW_W] == $past(addr[ROW_W-1:0]))); // R2
    AST_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_idle_o |-> !bank_open_o[$past(ba)]); // R3
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE && $past(addr[10])) |-> bank_open_o == '0); // R5
    AST_PREPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_o == PWR_PRE_PD |-> bank_open_o == '0); // R8
    AST_ACTPD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o == PWR_ACT_PD && $past(pwr_o) == PWR_ON) |-> bank_open_o != '0); // R8
    AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o != PWR_ON && $past(pwr_o) != PWR_ON) |->
        (cmd_o == CMD_NOP && $stable(open_row_o))); // R8
    AST_SREF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_SREF |-> pwr_o == PWR_SREF); // R9
    AST_CKE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        err_cke_o |-> !$past(cke)); // R11
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .NB(NB), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BA_W(BA_W)
) chk_i (.*);

// File: tb/ddr_cmd_tracker_tb_top.sv
module ddr_cmd_tracker_tb_top;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000, C_BST = 4'b0110, C_DES = 4'b1000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = '0, bl_sel = 2'd1;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_o;
    logic [9:0]  col_o;
    logic        auto_pre_o, mrs_ext_o;
    logic [3:0]  bank_open_o;
    logic [47:0] open_row_o;
    logic [1:0]  pwr_o;
    logic        err_idle_o, err_act_o, err_ref_o, err_cke_o;

    int checks = 0, errors = 0;

    typedef struct {
        logic [3:0] cmd;
        logic [3:0] open;
        logic [1:0] pwr;
        logic [3:0] err;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    ddr_cmd_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .bl_sel(bl_sel),
        .cmd_o(cmd_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
        .mrs_ext_o(mrs_ext_o), .bank_open_o(bank_open_o),
        .open_row_o(open_row_o), .pwr_o(pwr_o), .err_idle_o(err_idle_o),
        .err_act_o(err_act_o), .err_ref_o(err_ref_o), .err_cke_o(err_cke_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one command per cycle, expectation queued for the monitor
    task automatic step(input logic [3:0] c, input logic ck, input logic [1:0] b,
                        input logic [11:0] a, input logic [3:0] ec,
                        input logic [3:0] eo, input logic [1:0] ep,
                        input logic [3:0] ee, input string r);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        cke  = ck;
        ba   = b;
        addr = a;
        e.cmd = ec; e.open = eo; e.pwr = ep; e.err = ee; e.req = r;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // monitor: compares one queued item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [3:0] ae;
                e  = sb_q.pop_front();
                ae = {err_cke_o, err_ref_o, err_act_o, err_idle_o};
                checks++;
                if (cmd_o !== e.cmd || bank_open_o !== e.open ||
                    pwr_o !== e.pwr || ae !== e.err) begin
                    errors++;
                    $display("FAIL %s cmd/open/pwr/err actual=%h/%b/%0d/%b expected=%h/%b/%0d/%b",
                             e.req, cmd_o, bank_open_o, pwr_o, ae,
                             e.cmd, e.open, e.pwr, e.err);
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(cmd_o == 4'd0 && bank_open_o == 4'b0 && pwr_o == 2'd0 &&
              {err_cke_o, err_ref_o, err_act_o, err_idle_o} == 4'b0,
              "R12", "reset state", {cmd_o, bank_open_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(C_DES, 1, 2'd0, 12'h000, 4'd0, 4'b0000, 0, 4'b0000, "R1 deselect");
        step(C_RD,  1, 2'd0, 12'h000, 4'd2, 4'b0000, 0, 4'b0001, "R3 read idle");
        step(C_ACT, 1, 2'd1, 12'h5A5, 4'd1, 4'b0010, 0, 4'b0000, "R2 activate");
        check(open_row_o[23:12] == 12'h5A5, "R2", "row b1", open_row_o[23:12], 12'h5A5);
        step(C_ACT, 1, 2'd1, 12'h000, 4'd1, 4'b0010, 0, 4'b0010, "R3 act open");
        check(open_row_o[23:12] == 12'h5A5, "R3", "row kept", open_row_o[23:12], 12'h5A5);
        step(C_ACT, 1, 2'd2, 12'h123, 4'd1, 4'b0110, 0, 4'b0000, "R2 second bank");
        step(C_WR,  1, 2'd1, 12'hBFF, 4'd3, 4'b0110, 0, 4'b0000, "R12 write");
        check(col_o == 10'h3FF, "R4", "column", col_o, 10'h3FF);
        check(auto_pre_o == 1'b0, "R4", "auto pre", auto_pre_o, 0);
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0110, 0, 4'b0000, "R7 no ap");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0110, 0, 4'b0000, "R7 no ap");
        step(C_PRE, 1, 2'd2, 12'h000, 4'd4, 4'b0010, 0, 4'b0000, "R5 pre one");
        step(C_ACT, 1, 2'd3, 12'h007, 4'd1, 4'b1010, 0, 4'b0000, "R2 bank3");
        step(C_PRE, 1, 2'd0, 12'h400, 4'd4, 4'b0000, 0, 4'b0000, "R5 pre all");
        step(C_REF, 1, 2'd0, 12'h000, 4'd5, 4'b0000, 0, 4'b0000, "R6 ref idle");
        step(C_ACT, 1, 2'd0, 12'h001, 4'd1, 4'b0001, 0, 4'b0000, "R2 bank0");
        step(C_REF, 1, 2'd0, 12'h000, 4'd5, 4'b0001, 0, 4'b0100, "R6 ref open");
        step(C_RD,  1, 2'd0, 12'h404, 4'd2, 4'b0001, 0, 4'b0000, "R12 read ap");
        check(col_o == 10'h004, "R4", "column", col_o, 10'h004);
        check(auto_pre_o == 1'b1, "R4", "auto pre", auto_pre_o, 1);
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0001, 0, 4'b0000, "R7 bl4 open");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0000, 0, 4'b0000, "R7 bl4 closed");
        step(C_ACT, 1, 2'd0, 12'h002, 4'd1, 4'b0001, 0, 4'b0000, "R2 reopen");
        step(C_NOP, 0, 2'd0, 12'h000, 4'd0, 4'b0001, 2, 4'b0000, "R8 act pd");
        step(C_ACT, 0, 2'd2, 12'h0AA, 4'd0, 4'b0001, 2, 4'b0000, "R8 ignored");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0001, 0, 4'b0000, "R8 exit");
        step(C_PRE, 1, 2'd0, 12'h400, 4'd4, 4'b0000, 0, 4'b0000, "R5 pre all");
        step(C_NOP, 0, 2'd0, 12'h000, 4'd0, 4'b0000, 1, 4'b0000, "R8 pre pd");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0000, 0, 4'b0000, "R8 exit");
        step(C_REF, 0, 2'd0, 12'h000, 4'd8, 4'b0000, 3, 4'b0000, "R9 sref entry");
        step(C_NOP, 0, 2'd0, 12'h000, 4'd0, 4'b0000, 3, 4'b0000, "R9 sref hold");
        step(C_ACT, 1, 2'd1, 12'h055, 4'd0, 4'b0000, 0, 4'b0000, "R9 exit ignored");
        step(C_MRS, 1, 2'd1, 12'h000, 4'd6, 4'b0000, 0, 4'b0000, "R10 mrs ext");
        check(mrs_ext_o == 1'b1, "R10", "ext select", mrs_ext_o, 1);
        step(C_MRS, 1, 2'd0, 12'h000, 4'd6, 4'b0000, 0, 4'b0000, "R10 mrs base");
        check(mrs_ext_o == 1'b0, "R10", "ext select", mrs_ext_o, 0);
        step(C_ACT, 1, 2'd0, 12'h000, 4'd1, 4'b0001, 0, 4'b0000, "R2 bank0");
        step(C_RD,  1, 2'd0, 12'h000, 4'd2, 4'b0001, 0, 4'b0000, "R11 read");
        step(C_NOP, 0, 2'd0, 12'h000, 4'd0, 4'b0001, 2, 4'b1000, "R11 cke in burst");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0001, 0, 4'b0000, "R8 exit");
        step(C_PRE, 1, 2'd0, 12'h400, 4'd4, 4'b0000, 0, 4'b0000, "R5 pre all");
        bl_sel = 2'd2;
        step(C_ACT, 1, 2'd3, 12'h0F0, 4'd1, 4'b1000, 0, 4'b0000, "R2 bank3");
        step(C_RD,  1, 2'd3, 12'h400, 4'd2, 4'b1000, 0, 4'b0000, "R7 bl8 read");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b1000, 0, 4'b0000, "R7 bl8 open");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b1000, 0, 4'b0000, "R7 bl8 open");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b1000, 0, 4'b0000, "R7 bl8 open");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0000, 0, 4'b0000, "R7 bl8 closed");
        step(C_BST, 1, 2'd0, 12'h000, 4'd7, 4'b0000, 0, 4'b0000, "R12 burst stop");
        step(C_WR,  1, 2'd2, 12'h000, 4'd3, 4'b0000, 0, 4'b0001, "R3 write idle");
        step(C_NOP, 1, 2'd0, 12'h000, 4'd0, 4'b0000, 0, 4'b0000, "R12 nop");

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule